// File: doc/BRIEF.md
# Compare-and-branch next-PC unit

This unit resolves control-transfer instructions for a 64-bit register machine whose instructions occupy fixed 8-byte slots. Each issued instruction carries its program counter, a four-bit operation code, a three-bit class, a source-select bit, the two register values, a signed 16-bit offset and a 32-bit immediate. One cycle later the unit reports whether the branch is taken, the program counter of the next instruction, and whether the instruction was a call, an exit or an undefined operation.

Two classes are accepted. The wide class compares full 64-bit operands. The narrow class compares only the low 32 bits. The second operand is either the source register or the immediate, sign-extended. Eleven conditions are available: equality, inequality, any-common-bit, and four ordered tests each in unsigned and signed form. A taken branch moves the program counter by one slot more than the signed offset, counted in 8-byte slots. The unit does not act on calls or exits. It only flags them and passes the call immediate on to the stage that handles them.

Top module: `brcUnit`

## Requirements
- R1: While reset is held low and after it is released, outValid, taken, callFlag, exitFlag and illegal are 0 and nextPc is 0 until a valid instruction has been accepted.
- R2: An instruction is accepted when inValid is high and insnClass is 3'b101 (wide) or 3'b110 (narrow). outValid is high in the cycle after acceptance and only then. For any other class the input is ignored: outValid stays low and every result output keeps its previous value.
- R3: Operation code 1 is taken when the operands are equal, 5 when they differ, and 4 when their bitwise AND is non-zero.
- R4: Operation codes 2 (greater), 3 (greater or equal), 10 (less) and 11 (less or equal) compare the operands as unsigned numbers.
- R5: Operation codes 6 (greater), 7 (greater or equal), 12 (less) and 13 (less or equal) compare the operands as two's-complement signed numbers.
- R6: Class 3'b101 compares all 64 bits. Class 3'b110 compares only bits 31:0 of both operands, and the signed tests then use bit 31 as the sign.
- R7: When srcSel is 1 the second operand is srcVal. When srcSel is 0 it is imm sign-extended from bit 31 to the compare width.
- R8: A taken branch gives nextPc = curPc + (offset + 1) * 8. Here offset is the signed 16-bit value, the +1 is formed without 16-bit wrap, and the sum wraps modulo 2^64.
- R9: A conditional branch that is not taken gives nextPc = curPc + 8.
- R10: Operation code 0 is taken in both classes, whatever the register and immediate values are.
- R11: Operation code 8 raises callFlag, is not taken, gives nextPc = curPc + 8, and presents imm on callArg.
- R12: Operation code 9 raises exitFlag, is not taken, and gives nextPc = curPc + 8.
- R13: Operation codes 14 and 15 raise illegal, are not taken, and give nextPc = curPc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Instruction present this cycle |
| insnClass | input | 3 | Instruction class; 3'b101 wide, 3'b110 narrow |
| opCode | input | 4 | Branch operation code |
| srcSel | input | 1 | 1 selects srcVal, 0 selects the immediate |
| curPc | input | 64 | Program counter of the instruction |
| dstVal | input | 64 | First compare operand |
| srcVal | input | 64 | Register second operand |
| offset | input | 16 | Signed branch offset in slots |
| imm | input | 32 | Immediate operand |
| outValid | output | 1 | Result valid (one cycle after acceptance) |
| taken | output | 1 | Branch taken |
| nextPc | output | 64 | Next program counter |
| callFlag | output | 1 | Instruction was a call |
| exitFlag | output | 1 | Instruction was an exit |
| illegal | output | 1 | Undefined operation code |
| callArg | output | 32 | Immediate passed on for a call |

## Verification
Every operation code in both classes is swept against a set of operand values placed at the sign and carry boundaries of both widths. This set includes 0x7fffffff/0x80000000, values that differ only above bit 31, and all-ones. Mixed-sign pairs separate the signed tests from the unsigned ones. Pairs that are equal in the low word but differ in the high word separate the narrow class from the wide one. Immediates with bit 31 set show whether the immediate is sign-extended or zero-extended. Offsets of -1, 0x7fff and 0x8000, together with a program counter close to the top of the address space, exercise the biased target arithmetic and its wrap. An ignored class and a one-cycle valid pulse check that results are held.

// File: rtl/brc_pkg.sv
package brc_pkg;

  typedef enum logic [3:0] {
    OP_ALWAYS = 4'h0,
    OP_EQ     = 4'h1,
    OP_GTU    = 4'h2,
    OP_GEU    = 4'h3,
    OP_ANYSET = 4'h4,
    OP_NE     = 4'h5,
    OP_GTS    = 4'h6,
    OP_GES    = 4'h7,
    OP_CALL   = 4'h8,
    OP_EXIT   = 4'h9,
    OP_LTU    = 4'hA,
    OP_LEU    = 4'hB,
    OP_LTS    = 4'hC,
    OP_LES    = 4'hD
  } brOp_e;

  typedef enum logic [3:0] {
    CND_NEVER, CND_ALWAYS, CND_EQ, CND_NE, CND_ANY,
    CND_GTU, CND_GEU, CND_LTU, CND_LEU,
    CND_GTS, CND_GES, CND_LTS, CND_LES
  } cond_e;

  localparam logic [2:0] CLS_WIDE   = 3'b101;
  localparam logic [2:0] CLS_NARROW = 3'b110;

  typedef struct packed {
    logic  active;
    logic  narrow;
    logic  useReg;
    cond_e cond;
    logic  call;
    logic  exitP;
    logic  illegal;
  } brStrobe_t;

endpackage

// File: rtl/brcControl.sv
module brcControl
  import brc_pkg::*;
(
  input  logic       inValid,
  input  logic [2:0] insnClass,
  input  logic [3:0] opCode,
  input  logic       srcSel,
  output brStrobe_t  stb
);

  logic classOk;
  assign classOk = (insnClass == CLS_WIDE) || (insnClass == CLS_NARROW);

  always_comb begin
    stb         = '0;
    stb.cond    = CND_NEVER;
    stb.active  = inValid && classOk;
    stb.narrow  = (insnClass == CLS_NARROW);
    stb.useReg  = srcSel;
    case (opCode)
      OP_ALWAYS: stb.cond = CND_ALWAYS;
      OP_EQ:     stb.cond = CND_EQ;
      OP_NE:     stb.cond = CND_NE;
      OP_ANYSET: stb.cond = CND_ANY;
      OP_GTU:    stb.cond = CND_GTU;
      OP_GEU:    stb.cond = CND_GEU;
      OP_LTU:    stb.cond = CND_LTU;
      OP_LEU:    stb.cond = CND_LEU;
      OP_GTS:    stb.cond = CND_GTS;
      OP_GES:    stb.cond = CND_GES;
      OP_LTS:    stb.cond = CND_LTS;
      OP_LES:    stb.cond = CND_LES;
      OP_CALL:   stb.call = 1'b1;
      OP_EXIT:   stb.exitP = 1'b1;
      default:   stb.illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/brcCompare.sv
module brcCompare #(
  parameter int XLEN     = 64,
  parameter int NARROW_W = 32
) (
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  input  logic            narrow,
  output logic            isEq,
  output logic            isLtu,
  output logic            isLts,
  output logic            anySet
);

  logic [XLEN-1:0] aZ, bZ, aS, bS;

  generate
    if (NARROW_W < XLEN) begin : g_split
      localparam int PAD = XLEN - NARROW_W;
      always_comb begin
        if (narrow) begin
          aZ = {{PAD{1'b0}}, opA[NARROW_W-1:0]};
          bZ = {{PAD{1'b0}}, opB[NARROW_W-1:0]};
          aS = {{PAD{opA[NARROW_W-1]}}, opA[NARROW_W-1:0]};
          bS = {{PAD{opB[NARROW_W-1]}}, opB[NARROW_W-1:0]};
        end else begin
          aZ = opA;
          bZ = opB;
          aS = opA;
          bS = opB;
        end
      end
    end else begin : g_flat
      logic unusedNarrow;
      assign unusedNarrow = narrow;
      assign aZ = opA;
      assign bZ = opB;
      assign aS = opA;
      assign bS = opB;
    end
  endgenerate

  assign isEq   = (aZ == bZ);
  assign isLtu  = (aZ < bZ);
  assign isLts  = ($signed(aS) < $signed(bS));
  assign anySet = |(aZ & bZ);

endmodule

// File: rtl/brcDatapath.sv
module brcDatapath
  import brc_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int NARROW_W   = 32,
  parameter int PC_W       = 64,
  parameter int OFF_W      = 16,
  parameter int IMM_W      = 32,
  parameter int SLOT_BYTES = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  brStrobe_t        stb,
  input  logic [PC_W-1:0]  curPc,
  input  logic [XLEN-1:0]  dstVal,
  input  logic [XLEN-1:0]  srcVal,
  input  logic [OFF_W-1:0] offset,
  input  logic [IMM_W-1:0] imm,
  output logic             outValid,
  output logic             taken,
  output logic [PC_W-1:0]  nextPc,
  output logic             callFlag,
  output logic             exitFlag,
  output logic             illegal,
  output logic [IMM_W-1:0] callArg
);

  localparam int SHIFT = $clog2(SLOT_BYTES);
  localparam logic [PC_W-1:0] STEP = PC_W'(SLOT_BYTES);

  logic [XLEN-1:0] immExt, operandB;
  logic            isEq, isLtu, isLts, anySet;
  logic            condTrue;
  logic [PC_W-1:0] offPlus, branchTarget, seqPc, pcSel;

  assign immExt   = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
  assign operandB = stb.useReg ? srcVal : immExt;

  brcCompare #(.XLEN(XLEN), .NARROW_W(NARROW_W)) u_cmp (
    .opA   (dstVal),
    .opB   (operandB),
    .narrow(stb.narrow),
    .isEq  (isEq),
    .isLtu (isLtu),
    .isLts (isLts),
    .anySet(anySet)
  );

  always_comb begin
    case (stb.cond)
      CND_ALWAYS: condTrue = 1'b1;
      CND_EQ:     condTrue = isEq;
      CND_NE:     condTrue = !isEq;
      CND_ANY:    condTrue = anySet;
      CND_GTU:    condTrue = !isLtu && !isEq;
      CND_GEU:    condTrue = !isLtu;
      CND_LTU:    condTrue = isLtu;
      CND_LEU:    condTrue = isLtu || isEq;
      CND_GTS:    condTrue = !isLts && !isEq;
      CND_GES:    condTrue = !isLts;
      CND_LTS:    condTrue = isLts;
      CND_LES:    condTrue = isLts || isEq;
      default:    condTrue = 1'b0;
    endcase
  end

  assign offPlus      = {{(PC_W-OFF_W){offset[OFF_W-1]}}, offset} + PC_W'(1);
  assign branchTarget = curPc + (offPlus << SHIFT);
  assign seqPc        = curPc + STEP;

  always_comb begin
    if (condTrue)         pcSel = branchTarget;
    else if (stb.illegal) pcSel = curPc;
    else                  pcSel = seqPc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      taken    <= 1'b0;
      nextPc   <= '0;
      callFlag <= 1'b0;
      exitFlag <= 1'b0;
      illegal  <= 1'b0;
      callArg  <= '0;
    end else begin
      outValid <= stb.active;
      if (stb.active) begin
        taken    <= condTrue;
        nextPc   <= pcSel;
        callFlag <= stb.call;
        exitFlag <= stb.exitP;
        illegal  <= stb.illegal;
        callArg  <= imm;
      end
    end
  end

  a_r9_fallthrough: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !taken && !illegal |-> nextPc == $past(curPc) + STEP);

  a_r13_illegal_holds: assert property (@(posedge clk) disable iff (!rstN)
    outValid && illegal |-> (nextPc == $past(curPc)) && !taken);

  a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $onehot0({taken, callFlag, exitFlag, illegal}));

endmodule

// File: rtl/brcUnit.sv
module brcUnit
  import brc_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int NARROW_W   = 32,
  parameter int PC_W       = 64,
  parameter int OFF_W      = 16,
  parameter int IMM_W      = 32,
  parameter int SLOT_BYTES = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [2:0]       insnClass,
  input  logic [3:0]       opCode,
  input  logic             srcSel,
  input  logic [PC_W-1:0]  curPc,
  input  logic [XLEN-1:0]  dstVal,
  input  logic [XLEN-1:0]  srcVal,
  input  logic [OFF_W-1:0] offset,
  input  logic [IMM_W-1:0] imm,
  output logic             outValid,
  output logic             taken,
  output logic [PC_W-1:0]  nextPc,
  output logic             callFlag,
  output logic             exitFlag,
  output logic             illegal,
  output logic [IMM_W-1:0] callArg
);

  brStrobe_t stb;

  brcControl u_ctrl (
    .inValid  (inValid),
    .insnClass(insnClass),
    .opCode   (opCode),
    .srcSel   (srcSel),
    .stb      (stb)
  );

  brcDatapath #(
    .XLEN(XLEN), .NARROW_W(NARROW_W), .PC_W(PC_W),
    .OFF_W(OFF_W), .IMM_W(IMM_W), .SLOT_BYTES(SLOT_BYTES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .curPc   (curPc),
    .dstVal  (dstVal),
    .srcVal  (srcVal),
    .offset  (offset),
    .imm     (imm),
    .outValid(outValid),
    .taken   (taken),
    .nextPc  (nextPc),
    .callFlag(callFlag),
    .exitFlag(exitFlag),
    .illegal (illegal),
    .callArg (callArg)
  );

  a_r2_valid_source: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid) &&
      ($past(insnClass) == CLS_WIDE || $past(insnClass) == CLS_NARROW));

  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(nextPc) && $stable(taken));

  a_r10_always_taken: assert property (@(posedge clk) disable iff (!rstN)
    outValid && $past(opCode) == 4'h0 |-> taken);

endmodule

// File: tb/sim_brcUnit.sv
module sim_brcUnit;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [2:0]  insnClass;
  logic [3:0]  opCode;
  logic        srcSel;
  logic [63:0] curPc, dstVal, srcVal;
  logic [15:0] offset;
  logic [31:0] imm;
  logic        outValid, taken, callFlag, exitFlag, illegal;
  logic [63:0] nextPc;
  logic [31:0] callArg;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  brcUnit u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .insnClass(insnClass),
    .opCode(opCode), .srcSel(srcSel), .curPc(curPc), .dstVal(dstVal),
    .srcVal(srcVal), .offset(offset), .imm(imm), .outValid(outValid),
    .taken(taken), .nextPc(nextPc), .callFlag(callFlag),
    .exitFlag(exitFlag), .illegal(illegal), .callArg(callArg)
  );

  logic [63:0] vals [12];
  logic [31:0] imms [6];
  logic [15:0] offs [5];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string opTag(input logic [3:0] op);
    case (op)
      4'h0: return "R10";
      4'h1, 4'h4, 4'h5: return "R3";
      4'h2, 4'h3, 4'hA, 4'hB: return "R4";
      4'h6, 4'h7, 4'hC, 4'hD: return "R5";
      4'h8: return "R11";
      4'h9: return "R12";
      default: return "R13";
    endcase
  endfunction

  // Reference model computed from the requirements
  task automatic model(input logic [3:0] op, input bit nar, input logic [63:0] a,
                       input logic [63:0] b, input logic [63:0] pc, input logic [15:0] off,
                       output bit eT, output logic [63:0] eN);
    logic [63:0] au, bu;
    longint signed as_, bs_, offS;
    if (nar) begin
      au = {32'b0, a[31:0]}; bu = {32'b0, b[31:0]};
      as_ = longint'($signed(a[31:0])); bs_ = longint'($signed(b[31:0]));
    end else begin
      au = a; bu = b; as_ = $signed(a); bs_ = $signed(b);
    end
    case (op)
      4'h0: eT = 1;
      4'h1: eT = (au == bu);
      4'h5: eT = (au != bu);
      4'h4: eT = ((au & bu) != 0);
      4'h2: eT = (au > bu);
      4'h3: eT = (au >= bu);
      4'hA: eT = (au < bu);
      4'hB: eT = (au <= bu);
      4'h6: eT = (as_ > bs_);
      4'h7: eT = (as_ >= bs_);
      4'hC: eT = (as_ < bs_);
      4'hD: eT = (as_ <= bs_);
      default: eT = 0;
    endcase
    offS = longint'($signed(off));
    if (eT) eN = pc + 64'((offS + 1) * 8);          // R8
    else if (op >= 4'hE) eN = pc;                   // R13
    else eN = pc + 64'd8;                           // R9
  endtask

  task automatic runVec(input logic [2:0] cls, input logic [3:0] op, input bit sel,
                        input logic [63:0] a, input logic [63:0] rb, input logic [31:0] im,
                        input logic [63:0] pc, input logic [15:0] off);
    bit eT;
    logic [63:0] eN, b;
    string tag;
    inValid = 1; insnClass = cls; opCode = op; srcSel = sel;
    dstVal = a; srcVal = rb; imm = im; curPc = pc; offset = off;
    b = sel ? rb : {{32{im[31]}}, im};
    model(op, cls == 3'b110, a, b, pc, off, eT, eN);
    @(negedge clk);
    tag = opTag(op);
    if (cls == 3'b110) tag = {tag, "/R6"};
    if (!sel) tag = {tag, "/R7"};
    chk(outValid === 1'b1, {tag, "/R2 valid"}, 64'(outValid), 64'd1);
    chk(taken === eT, {tag, " taken"}, 64'(taken), 64'(eT));
    chk(nextPc === eN, {tag, eT ? "/R8 pc" : "/R9 pc"}, nextPc, eN);
    chk(callFlag === (op == 4'h8), "R11 callFlag", 64'(callFlag), 64'(op == 4'h8));
    chk(exitFlag === (op == 4'h9), "R12 exitFlag", 64'(exitFlag), 64'(op == 4'h9));
    chk(illegal === (op >= 4'hE), "R13 illegal", 64'(illegal), 64'(op >= 4'hE));
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    vals = '{64'h0, 64'h1, 64'h7fff_ffff, 64'h8000_0000, 64'hffff_ffff,
             64'h1_0000_0000, 64'h7fff_ffff_ffff_ffff, 64'h8000_0000_0000_0000,
             64'hffff_ffff_ffff_ffff, 64'hffff_ffff_0000_0001,
             64'h1_8000_0000, 64'h5};
    imms = '{32'h0, 32'h1, 32'h7fff_ffff, 32'h8000_0000, 32'hffff_ffff, 32'h5};
    offs = '{16'h0, 16'h1, 16'hffff, 16'h7fff, 16'h8000};

    rstN = 0; inValid = 0; insnClass = 0; opCode = 0; srcSel = 0;
    curPc = 0; dstVal = 0; srcVal = 0; offset = 0; imm = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(outValid === 0 && taken === 0 && callFlag === 0 && exitFlag === 0 && illegal === 0,
        "R1 flags", {59'b0, outValid, taken, callFlag, exitFlag, illegal}, 64'd0);
    chk(nextPc === 64'd0, "R1 nextPc", nextPc, 64'd0);
    rstN = 1;
    @(negedge clk);
    chk(outValid === 0 && nextPc === 64'd0, "R1 after release", nextPc, 64'd0);

    // Sweep: both classes, all codes, register and immediate operands
    for (int c = 0; c < 2; c++) begin
      for (int op = 0; op < 16; op++) begin
        for (int i = 0; i < 12; i++) begin
          for (int j = 0; j < 12; j++)
            runVec(c ? 3'b110 : 3'b101, 4'(op), 1'b1, vals[i], vals[j], 32'h0,
                   64'h1000 + 64'(j * 64), offs[(i + j) % 5]);
          for (int k = 0; k < 6; k++)
            runVec(c ? 3'b110 : 3'b101, 4'(op), 1'b0, vals[i], vals[(k + 3) % 12], imms[k],
                   64'h4000 + 64'(k * 8), offs[(i + k) % 5]);
        end
      end
    end

    // R8: target wraps past the top of the address space
    runVec(3'b101, 4'h0, 1'b1, 0, 0, 0, 64'hffff_ffff_ffff_fff8, 16'h0002);
    chk(nextPc === 64'h10, "R8 wrap", nextPc, 64'h10);
    // R8: +1 formed without 16-bit wrap
    runVec(3'b101, 4'h0, 1'b1, 0, 0, 0, 64'h0, 16'h7fff);
    chk(nextPc === 64'h4_0000, "R8 max offset", nextPc, 64'h4_0000);

    // R11: callArg carries the immediate
    runVec(3'b101, 4'h8, 1'b0, 0, 0, 32'hdead_beef, 64'h200, 16'h0);
    chk(callArg === 32'hdead_beef, "R11 callArg", 64'(callArg), 64'hdead_beef);

    // R2: ignored class, results held
    held = nextPc;
    inValid = 1; insnClass = 3'b100; opCode = 4'h0; curPc = 64'h9990; offset = 16'h10;
    @(negedge clk);
    chk(outValid === 1'b0, "R2 ignored class valid", 64'(outValid), 64'd0);
    chk(nextPc === held, "R2 ignored class held", nextPc, held);
    // R2: valid is a single-cycle pulse
    inValid = 0; insnClass = 3'b101;
    @(negedge clk);
    chk(outValid === 1'b0 && nextPc === held, "R2 idle hold", nextPc, held);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule